// File: doc/BRIEF.md
# Two-Stage UART Bit-Rate Generator with Receive Timeout

This block turns the system clock into the timing pulses a UART needs. A selectable divide-by-8 prescaler feeds a 16-bit tick counter, which emits a single-cycle baud tick once per configured count. A second counter divides those ticks by (divisor + 1) to give the per-bit enable. The bit rate is therefore the selected clock over (tick count × (divisor + 1)).

Configuration arrives as plain register writes on a 2-bit select. Writes that would give an illegal tick count (below 1) or an illegal divisor (below 4) are dropped silently, so the previous value stays in force. An accepted write to the mode, tick-count or divisor register restarts both counters. This means a new setting never produces one short, stale period.

A receive-timeout timer is restarted by each received-byte pulse. It counts bit enables up to four character times, where a character time is the frame length set by the mode register. It raises a one-cycle timeout pulse when that count is reached, but only if the timeout register holds a nonzero value. Serial shifting is left to the transmitter and receiver that use these pulses.

Top module: `ubt_baud_timer`

## Requirements
- R1: Mode bit 0 selects the prescaler. When it is 0 the tick counter advances every clock. When it is 1 it advances every 8th clock, so the baud tick period is 8 × CD clocks instead of CD clocks.
- R2: `baud_tick` is a single-cycle pulse that repeats every CD prescaled clocks (period P×CD, P = 1 or 8).
- R3: `bit_en` is a single-cycle pulse on every (BDIV+1)-th baud tick (period P×CD×(BDIV+1)), and it only follows a cycle in which `baud_tick` was high.
- R4: A write with `wr_sel` = 1 (CD) is accepted only if the whole data word is at least 1, and only its low 16 bits are kept. A rejected write changes neither the period nor the phase of `baud_tick`.
- R5: A write with `wr_sel` = 2 (BDIV) is accepted only if the whole data word is at least 4, and only its low 8 bits are kept. A rejected write leaves the `bit_en` period and phase unchanged.
- R6: After reset CD = 0x28B, BDIV = 0xF, mode = 0 and timeout register = 0, and all outputs are low. The baud tick period is therefore 651 clocks and the bit period is 10416 clocks.
- R7: An accepted write to mode, CD or BDIV restarts both counters. Counting write edges from the write's own edge, the first `baud_tick` is seen P×CD clocks later, and the first `bit_en` is seen P×CD×(BDIV+1)+1 clocks later.
- R8: Frame length is 1 start bit plus data bits plus optional parity plus stop bits, decoded from the mode register. Data bits come from mode[2:1]: 3 gives 6 bits, 2 gives 7 bits, and any other value gives 8 bits. Parity comes from mode[5:3]: 0 or 1 adds one bit, any other value adds none. Stop bits come from mode[7:6]: 3 gives 1 stop bit, any other value gives 2.
- R9: After a `rx_byte` pulse, `rx_timeout` pulses high for exactly one cycle in the cycle after the 4×frame-length-th `bit_en`. The counting starts with the first `bit_en` after the pulse.
- R10: A further `rx_byte` pulse restarts the timeout count from zero, and no timeout is produced from the earlier pulse.
- R11: A write with `wr_sel` = 3 sets the timeout register. While its value is zero, no `rx_timeout` is produced. Writing it does not restart the rate counters.
- R12: Register selects are 0 = mode, 1 = CD, 2 = BDIV and 3 = timeout. A write takes effect on the clock edge at which `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 mode, 1 CD, 2 BDIV, 3 timeout) |
| wr_data | input | DATA_W | Write data word |
| rx_byte | input | 1 | One-cycle pulse per received byte |
| baud_tick | output | 1 | Single-cycle baud tick |
| bit_en | output | 1 | Single-cycle per-bit enable |
| rx_timeout | output | 1 | Single-cycle receive-timeout pulse |

## Verification
The rate path is exercised in several ways:
- The reset settings.
- Directed small counts, both with and without the prescaler.
- Boundary writes: CD of 1, BDIV of 4, and words whose upper bits are set but are discarded.
- Random count, divisor and mode combinations.

Period measurements separate the prescaler choice from the CD and BDIV factors. First-pulse latency after a write shows whether the counters restart.

Rejected writes are placed in the middle of a period, so any disturbance of phase shows up as a changed interval. The same is done with a timeout-register write.

The timeout is run under four mode encodings with distinct frame lengths (8, 10, 11 and 12 bits). This tells apart each field decode of R8. Further runs cover a restarting second byte and a zero timeout register.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_CD   = 2'd1,
        SEL_BDIV = 2'd2,
        SEL_TMO  = 2'd3
    } ubt_sel_e;

    localparam int MODE_W    = 8;
    localparam int FRAME_W   = 4;
    localparam int MAX_FRAME = 12;
    localparam int CD_MIN    = 1;
    localparam int BDIV_MIN  = 4;
    localparam int SLOW_DIV  = 8;

    // Bits per character: start + data + optional parity + stop
    function automatic logic [FRAME_W-1:0] frame_len(input logic [MODE_W-1:0] mode);
        logic [FRAME_W-1:0] n;
        case (mode[2:1])
            2'd3:    n = 4'd7;   // start + 6 data
            2'd2:    n = 4'd8;   // start + 7 data
            default: n = 4'd9;   // start + 8 data
        endcase
        if (mode[5:4] == 2'b00) begin
            n = n + 4'd1;        // even or odd parity bit present
        end
        n = n + ((mode[7:6] == 2'd3) ? 4'd1 : 4'd2);
        return n;
    endfunction

endpackage

// File: rtl/ubt_cfg_regs.sv
module ubt_cfg_regs
    import ubt_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          CD_W    = 16,
    parameter int          DIV_W   = 8,
    parameter int          TMO_W   = 8,
    parameter int unsigned CD_RST  = 32'h28B,
    parameter int unsigned DIV_RST = 32'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_o,
    output logic [CD_W-1:0]   cd_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [TMO_W-1:0]  tmo_o,
    output logic              restart_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CD_W-1:0]   cd;
        logic [DIV_W-1:0]  div;
        logic [TMO_W-1:0]  tmo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic restart_d;
    logic cd_legal, div_legal;

    assign cd_legal  = (wr_data >= DATA_W'(CD_MIN));
    assign div_legal = (wr_data >= DATA_W'(BDIV_MIN));

    always_comb begin
        cfg_d     = cfg_q;
        restart_d = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_MODE: begin
                    cfg_d.mode = wr_data[MODE_W-1:0];
                    restart_d  = 1'b1;
                end
                SEL_CD: begin
                    if (cd_legal) begin
                        cfg_d.cd  = wr_data[CD_W-1:0];
                        restart_d = 1'b1;
                    end
                end
                SEL_BDIV: begin
                    if (div_legal) begin
                        cfg_d.div = wr_data[DIV_W-1:0];
                        restart_d = 1'b1;
                    end
                end
                default: begin
                    cfg_d.tmo = wr_data[TMO_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= '0;
            cfg_q.cd   <= CD_W'(CD_RST);
            cfg_q.div  <= DIV_W'(DIV_RST);
            cfg_q.tmo  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o    = cfg_q.mode;
    assign cd_o      = cfg_q.cd;
    assign div_o     = cfg_q.div;
    assign tmo_o     = cfg_q.tmo;
    assign restart_o = restart_d;

endmodule

// File: rtl/ubt_tick_gen.sv
module ubt_tick_gen #(
    parameter int CD_W     = 16,
    parameter int PRESCALE = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            slow_i,
    input  logic [CD_W-1:0] cd_i,
    output logic            tick_o
);

    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic [CD_W-1:0] cnt;
        logic            tick;
    } tg_t;

    tg_t  st_d, st_q;
    logic ce;

    generate
        if (PRESCALE > 1) begin : g_prescale
            assign ce = !slow_i || (st_q.ps == PS_W'(PRESCALE - 1));
        end else begin : g_direct
            assign ce = 1'b1 | slow_i;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart_i) begin
            st_d = '0;
        end else begin
            if (slow_i && !ce) begin
                st_d.ps = st_q.ps + 1'b1;
            end else begin
                st_d.ps = '0;
            end
            if (ce) begin
                if (st_q.cnt == CD_W'(cd_i - 1'b1)) begin
                    st_d.cnt  = '0;
                    st_d.tick = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/ubt_bit_div.sv
module ubt_bit_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bit_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bit_en;
    } bd_t;

    bd_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.bit_en = 1'b0;
        if (restart_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (st_q.cnt == div_i) begin
                st_d.cnt    = '0;
                st_d.bit_en = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.bit_en;

endmodule

// File: rtl/ubt_rx_timer.sv
module ubt_rx_timer
    import ubt_pkg::*;
#(
    parameter int TMO_W     = 8,
    parameter int TMO_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_byte_i,
    input  logic               bit_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [TMO_W-1:0]   tmo_i,
    output logic               timeout_o
);

    localparam int LIM_W = $clog2(MAX_FRAME * TMO_CHARS + 1);

    typedef struct packed {
        logic             armed;
        logic [LIM_W-1:0] cnt;
        logic             fire;
    } rt_t;

    rt_t              st_d, st_q;
    logic [LIM_W-1:0] limit;

    assign limit = LIM_W'(TMO_CHARS * int'(frame_i));

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (rx_byte_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed && bit_i) begin
            if (st_q.cnt == LIM_W'(limit - 1'b1)) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.fire  = |tmo_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout_o = st_q.fire;

endmodule

// File: rtl/ubt_baud_timer.sv
module ubt_baud_timer
    import ubt_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          CD_W      = 16,
    parameter int          DIV_W     = 8,
    parameter int          TMO_W     = 8,
    parameter int          TMO_CHARS = 4,
    parameter int unsigned CD_RST    = 32'h28B,
    parameter int unsigned DIV_RST   = 32'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_byte,
    output logic              baud_tick,
    output logic              bit_en,
    output logic              rx_timeout
);

    logic [MODE_W-1:0]  cfg_mode;
    logic [CD_W-1:0]    cfg_cd;
    logic [DIV_W-1:0]   cfg_div;
    logic [TMO_W-1:0]   cfg_tmo;
    logic               restart;
    logic [FRAME_W-1:0] frame_bits;

    ubt_cfg_regs #(
        .DATA_W (DATA_W),
        .CD_W   (CD_W),
        .DIV_W  (DIV_W),
        .TMO_W  (TMO_W),
        .CD_RST (CD_RST),
        .DIV_RST(DIV_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mode_o   (cfg_mode),
        .cd_o     (cfg_cd),
        .div_o    (cfg_div),
        .tmo_o    (cfg_tmo),
        .restart_o(restart)
    );

    ubt_tick_gen #(
        .CD_W    (CD_W),
        .PRESCALE(SLOW_DIV)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .slow_i   (cfg_mode[0]),
        .cd_i     (cfg_cd),
        .tick_o   (baud_tick)
    );

    ubt_bit_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .tick_i   (baud_tick),
        .div_i    (cfg_div),
        .bit_o    (bit_en)
    );

    always_comb begin
        frame_bits = frame_len(cfg_mode);
    end

    ubt_rx_timer #(
        .TMO_W    (TMO_W),
        .TMO_CHARS(TMO_CHARS)
    ) u_rxto (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte_i(rx_byte),
        .bit_i    (bit_en),
        .frame_i  (frame_bits),
        .tmo_i    (cfg_tmo),
        .timeout_o(rx_timeout)
    );

endmodule

// File: rtl/ubt_checker.sv
module ubt_checker
    import ubt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CD_W   = 16,
    parameter int DIV_W  = 8,
    parameter int TMO_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              rx_byte,
    input logic              baud_tick,
    input logic              bit_en,
    input logic              rx_timeout,
    input logic [CD_W-1:0]   cfg_cd,
    input logic [DIV_W-1:0]  cfg_div,
    input logic [TMO_W-1:0]  cfg_tmo
);

    logic cd_wr, div_wr;
    assign cd_wr  = wr_en && (wr_sel == SEL_CD);
    assign div_wr = wr_en && (wr_sel == SEL_BDIV);

    AST_CD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        cd_wr && (wr_data < DATA_W'(CD_MIN)) |=> $stable(cfg_cd)); // R4

    AST_CD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cd_wr && (wr_data >= DATA_W'(CD_MIN)) |=> cfg_cd == $past(wr_data[CD_W-1:0])); // R4

    AST_DIV_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr && (wr_data < DATA_W'(BDIV_MIN)) |=> $stable(cfg_div)); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_wr && (wr_data >= DATA_W'(CD_MIN))) || (div_wr && (wr_data >= DATA_W'(BDIV_MIN)))
        |=> !baud_tick && !bit_en); // R7

    AST_BIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> $past(baud_tick)); // R3

    AST_TMO_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> $past(bit_en)); // R9

    AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout); // R9

    AST_TMO_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> !$past(rx_byte)); // R10

    AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> $past(cfg_tmo) != '0); // R11

endmodule

bind ubt_baud_timer ubt_checker #(
    .DATA_W(DATA_W),
    .CD_W  (CD_W),
    .DIV_W (DIV_W),
    .TMO_W (TMO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rx_byte   (rx_byte),
    .baud_tick (baud_tick),
    .bit_en    (bit_en),
    .rx_timeout(rx_timeout),
    .cfg_cd    (cfg_cd),
    .cfg_div   (cfg_div),
    .cfg_tmo   (cfg_tmo)
);

// File: tb/tb_ubt_baud_timer.sv
`timescale 1ns/1ps
module tb_ubt_baud_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        rx_byte = 1'b0;
    wire         baud_tick;
    wire         bit_en;
    wire         rx_timeout;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the configuration
    int m_mode = 0;
    int m_cd   = 32'h28B;
    int m_div  = 15;

    always #2.5 clk = ~clk;

    ubt_baud_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rx_byte   (rx_byte),
        .baud_tick (baud_tick),
        .bit_en    (bit_en),
        .rx_timeout(rx_timeout)
    );

    function automatic int pre_of(int mode);
        return (mode % 2 == 1) ? 8 : 1;
    endfunction

    function automatic int tick_per();
        return pre_of(m_mode) * ((m_cd == 0) ? 65536 : m_cd);
    endfunction

    function automatic int bit_per();
        return tick_per() * (m_div + 1);
    endfunction

    function automatic int frame_of(int mode);
        int n;
        int d;
        int p;
        int s;
        d = (mode >> 1) & 3;
        p = (mode >> 3) & 7;
        s = (mode >> 6) & 3;
        n = 1 + ((d == 3) ? 6 : (d == 2) ? 7 : 8);
        if (p <= 1) n = n + 1;
        n = n + ((s == 3) ? 1 : 2);
        return n;
    endfunction

    function automatic logic sigv(int s);
        case (s)
            0:       return baud_tick;
            1:       return bit_en;
            default: return rx_timeout;
        endcase
    endfunction

    task automatic check(int got, int exp, string req, string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model_wr(int sel, logic [31:0] data);
        case (sel)
            0: m_mode = int'(data & 32'hFF);
            1: if (data >= 1) m_cd = int'(data & 32'hFFFF);
            2: if (data >= 4) m_div = int'(data & 32'hFF);
            default: ;
        endcase
    endtask

    // Drive one write; returns at the first falling edge after the write edge
    task automatic wr(int sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(sel, data);
    endtask

    // Index of falling edges (current = 1) until signal s is seen high
    task automatic first_high(int s, output int k);
        k = 1;
        while (!sigv(s) && k < 150000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic period_of(int s, output int p);
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!sigv(s) && guard < 150000);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!sigv(s) && p < 150000);
    endtask

    // Interval between two pulses of s with a write issued just after the first
    task automatic period_across(int s, int sel, logic [31:0] data, output int p);
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!sigv(s) && guard < 150000);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_data = data;
        p = 1;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(sel, data);
        p = 2;
        while (!sigv(s) && p < 150000) begin
            @(negedge clk);
            p++;
        end
    endtask

    task automatic pulse_rx();
        @(negedge clk);
        rx_byte = 1'b1;
        @(negedge clk);
        rx_byte = 1'b0;
    endtask

    // After a rx pulse: falling-edge index of the first timeout, the expected index, and count of highs
    task automatic watch_timeout(int frame, output int got, output int exp, output int highs);
        int bits;
        int idx;
        bits = 0;
        got = -1;
        exp = -1;
        highs = 0;
        idx = 1;
        while (idx < 2000 && (exp < 0 || idx <= exp + 4)) begin
            if (rx_timeout) begin
                highs++;
                if (got < 0) got = idx;
            end
            if (bit_en) begin
                bits++;
                if (bits == 4 * frame) exp = idx + 1;
            end
            @(negedge clk);
            idx++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): cycles actual 200000 expected fewer");
        summary();
        $finish;
    end

    initial begin
        int p;
        int k;
        int got;
        int exp;
        int highs;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state of outputs and reset rates
        check(int'({baud_tick, bit_en, rx_timeout}), 0, "R6", "outputs after reset");
        period_of(0, p);
        check(p, 651, "R6", "reset baud tick period");
        period_of(1, p);
        check(p, 10416, "R6", "reset bit period");

        // R7 / R2: restart latency and period for CD
        wr(1, 32'd5);
        first_high(0, k);
        check(k, tick_per() + 1, "R7", "first tick after CD write");
        period_of(0, p);
        check(p, 5, "R2", "tick period CD=5");
        // R7 / R3: BDIV restart latency and period
        wr(2, 32'd4);
        first_high(1, k);
        check(k, bit_per() + 2, "R7", "first bit enable after BDIV write");
        period_of(1, p);
        check(p, 25, "R3", "bit period CD=5 BDIV=4");

        // R1: prescaler
        wr(0, 32'h1);
        first_high(0, k);
        check(k, 41, "R1", "first tick with prescaler");
        period_of(0, p);
        check(p, 40, "R1", "tick period with prescaler");
        period_of(1, p);
        check(p, 200, "R1", "bit period with prescaler");
        wr(0, 32'h0);

        // R4: rejected CD write keeps period and phase
        period_across(0, 1, 32'd0, p);
        check(p, 5, "R4", "tick interval across rejected CD write");
        // R5: rejected BDIV write keeps period and phase
        period_across(1, 2, 32'd3, p);
        check(p, 25, "R5", "bit interval across rejected BDIV write");
        // R11 / R12: timeout register write does not restart
        period_across(0, 3, 32'd9, p);
        check(p, 5, "R12", "tick interval across timeout write");

        // R4: upper bits discarded, accepted
        wr(1, 32'h0001_0003);
        period_of(0, p);
        check(p, 3, "R4", "tick period after 0x10003 write");
        // R5: upper bits discarded
        wr(2, 32'h0000_0105);
        period_of(1, p);
        check(p, 18, "R5", "bit period after 0x105 write");
        // R5: boundary 4 accepted
        wr(2, 32'd4);
        period_of(1, p);
        check(p, 15, "R5", "bit period BDIV=4 boundary");
        // R4: boundary 1 accepted
        wr(1, 32'd1);
        period_of(0, p);
        check(p, 1, "R4", "tick period CD=1 boundary");

        // Random rate combinations: R1 R2 R3
        for (int i = 0; i < 6; i++) begin
            logic [31:0] rc;
            logic [31:0] rd;
            logic [31:0] rm;
            rc = 32'd1 + ($urandom % 12);
            rd = 32'd4 + ($urandom % 6);
            rm = $urandom % 256;
            wr(0, rm);
            wr(1, rc);
            wr(2, rd);
            if ($urandom % 2 == 1) wr(1, 32'd0);
            period_of(0, p);
            check(p, tick_per(), "R2", "random tick period");
            period_of(1, p);
            check(p, bit_per(), "R3", "random bit period");
        end

        // Timeout: bit period 5 clocks, several frame lengths (R8, R9)
        wr(1, 32'd1);
        wr(2, 32'd4);
        wr(3, 32'd1);
        begin
            int modes [4] = '{32'h00, 32'hE6, 32'h4C, 32'hD2};
            int frames [4] = '{12, 8, 11, 10};
            for (int i = 0; i < 4; i++) begin
                wr(0, 32'(modes[i]));
                check(frame_of(m_mode), frames[i], "R8", "bench frame decode");
                pulse_rx();
                watch_timeout(frame_of(m_mode), got, exp, highs);
                check(got, exp, "R8", "timeout position for mode");
                check(highs, 1, "R9", "timeout pulse count");
            end
        end

        // R10: second byte restarts the timer
        wr(0, 32'hE6);
        pulse_rx();
        k = 0;
        highs = 0;
        while (k < 10) begin
            @(negedge clk);
            if (bit_en) k++;
            if (rx_timeout) highs++;
        end
        pulse_rx();
        watch_timeout(8, got, exp, p);
        check(highs, 0, "R10", "no timeout before restart");
        check(got, exp, "R10", "timeout position after second byte");

        // R11: zero timeout register suppresses
        wr(3, 32'd0);
        pulse_rx();
        watch_timeout(8, got, exp, highs);
        check(highs, 0, "R11", "timeout with zero register");

        summary();
        $finish;
    end

endmodule